// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for a parallel LCD panel. It drives a horizontal sync, a vertical sync, a data-enable strobe, the column index of the current active pixel and the row index of the current active line. Every step is gated by a pixel-clock enable that a divider outside the block derives from the system clock. Configuration inputs set each phase of a line: a delay that follows the line start, the sync pulse, the back porch, the active pixels and the front porch. The delay that opens a line also lengthens the gap between the last pixel and the next sync pulse. Further inputs set the vertical sync width, the vertical porches, the number of active lines and the panel type.

All configuration is copied into shadow registers at the start of a frame, so software may rewrite it at any time without tearing a line. A TFT frame holds sync lines, then back-porch lines, then active lines, then front-porch lines. An STN frame holds only active lines, and its vertical sync covers one full line, starting at the first active pixel. A registered flag reports a configuration that the downstream pixel datapath cannot serve: the clocks available before the first pixel are too few, or the active width is below the minimum.

Top module: `lcd_sync_gen`

## Requirements
- R1: All timing state advances only on clock edges where `pix_en` is high; on any other edge `hsync`, `vsync`, `de`, `pix_x` and `line_y` keep their values.
- R2: Each line is, in pixel ticks: a start delay of `vh_dly+1`, then `hsync` high for `h_pulse+1`, then a back porch of `h_back+1`, then `h_active+1` active pixels, then a front porch of `h_front+1`. The gap from the last active pixel to the next `hsync` is therefore `h_front+vh_dly+2` ticks.
- R3: `de` is high only on active pixels of active lines. `pix_x` counts 0 up to `h_active` across those pixels. `pix_x` and `line_y` are both 0 whenever `de` is low.
- R4: In TFT mode (`stn_mode`=0) a frame has `v_pulse+1` lines with `vsync` high from the start of the first line, then `v_back` inactive lines, then `v_active+1` active lines (`line_y` 0 to `v_active`), then `v_front` inactive lines.
- R5: In STN mode (`stn_mode`=1) a frame has `v_active+1` lines, all active. `vsync` goes high at the first active pixel of line 0 and falls at the first active pixel of line 1. `v_pulse`, `v_back` and `v_front` have no effect.
- R6: Every configuration input, `stn_mode` included, is sampled when a frame starts. A change made during a frame first takes effect on the following frame.
- R7: While `rst` is high, and after it until the first `pix_en`, every output is low. The first `pix_en` opens a frame at the first tick of line 0.
- R8: `cfg_err` is a register updated on every clock. It is high one clock after the live inputs satisfy `(vh_dly+h_pulse+h_back+3)*pclk_div < DPATH_LAT` or `h_active==0`, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable, one system cycle per pixel tick |
| stn_mode | input | 1 | Panel type: 1 = STN, 0 = TFT |
| vh_dly | input | H_W | Line start delay minus one |
| h_pulse | input | H_W | Horizontal sync width minus one |
| h_back | input | H_W | Horizontal back porch minus one |
| h_front | input | H_W | Horizontal front porch minus one |
| h_active | input | H_W | Active pixels per line minus one |
| v_pulse | input | V_W | Vertical sync width in lines minus one (TFT) |
| v_back | input | V_W | Vertical back porch lines (TFT) |
| v_front | input | V_W | Vertical front porch lines (TFT) |
| v_active | input | V_W | Active lines per frame minus one |
| pclk_div | input | PW | Pixel clock period in system clocks |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | H_W | Active pixel index within the line |
| line_y | output | V_W | Active line index within the frame |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
A model in the bench counts pixel ticks from the start of the frame and is compared with every output on every clock. It goes after these corner cases. All-zero porches with a two-pixel line would expose an off-by-one in any phase limit, seen as a wrong `hsync` or `de` length. A mid-frame rewrite of the timing would tear the current line in a design without shadow registers. An STN run with nonzero vertical porches would show extra inactive lines, or a `vsync` on the line boundary instead of the active-pixel boundary. Sparse, irregular `pix_en` would catch logic that advances on system clocks. Sweeping `pclk_div` and `h_active` past the legality limit catches an inverted or non-inclusive bound on `cfg_err`.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

    // Horizontal phases in the order they occur along a line.
    typedef enum logic [2:0] {
        PH_DLY   = 3'd0,
        PH_SYNC  = 3'd1,
        PH_BACK  = 3'd2,
        PH_ACT   = 3'd3,
        PH_FRONT = 3'd4
    } hphase_e;

endpackage

// File: rtl/lcd_hline.sv
module lcd_hline
    import lcd_sync_pkg::*;
#(
    parameter int H_W = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           adv,
    input  logic [H_W-1:0] len_dly,
    input  logic [H_W-1:0] len_sync,
    input  logic [H_W-1:0] len_back,
    input  logic [H_W-1:0] len_act,
    input  logic [H_W-1:0] len_front,
    output hphase_e        phase,
    output logic [H_W-1:0] cnt,
    output logic           line_end
);

    typedef struct packed {
        hphase_e        ph;
        logic [H_W-1:0] cnt;
    } hst_t;

    hst_t st_d, st_q;
    logic [H_W-1:0] lim;

    always_comb begin
        unique case (st_q.ph)
            PH_DLY:   lim = len_dly;
            PH_SYNC:  lim = len_sync;
            PH_BACK:  lim = len_back;
            PH_ACT:   lim = len_act;
            default:  lim = len_front;
        endcase

        st_d     = st_q;
        line_end = adv && (st_q.ph == PH_FRONT) && (st_q.cnt == lim);
        if (adv) begin
            if (st_q.cnt == lim) begin
                st_d.cnt = '0;
                unique case (st_q.ph)
                    PH_DLY:  st_d.ph = PH_SYNC;
                    PH_SYNC: st_d.ph = PH_BACK;
                    PH_BACK: st_d.ph = PH_ACT;
                    PH_ACT:  st_d.ph = PH_FRONT;
                    default: st_d.ph = PH_DLY;
                endcase
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_DLY, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;
    assign cnt   = st_q.cnt;

endmodule

// File: rtl/lcd_vframe.sv
module lcd_vframe #(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic [LW-1:0] last_line,
    output logic [LW-1:0] vline,
    output logic          frame_end
);

    logic [LW-1:0] vline_d, vline_q;

    always_comb begin
        frame_end = line_end && (vline_q == last_line);
        vline_d   = vline_q;
        if (line_end) begin
            vline_d = (vline_q == last_line) ? '0 : vline_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vline_q <= '0;
        end else begin
            vline_q <= vline_d;
        end
    end

    assign vline = vline_q;

endmodule

// File: rtl/lcd_cfg_check.sv
module lcd_cfg_check #(
    parameter int H_W       = 10,
    parameter int PW        = 8,
    parameter int DPATH_LAT = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [H_W-1:0] vh,
    input  logic [H_W-1:0] hpw,
    input  logic [H_W-1:0] hbp,
    input  logic [H_W-1:0] hoz,
    input  logic [PW-1:0]  per,
    output logic           err
);

    localparam int SW = H_W + 2;
    localparam int MW = SW + PW;

    logic [SW-1:0] lead;
    logic [MW-1:0] lead_clks;
    logic          err_d, err_q;

    always_comb begin
        lead      = SW'(vh) + SW'(hpw) + SW'(hbp) + SW'(3);
        lead_clks = MW'(lead) * MW'(per);
        err_d     = (lead_clks < MW'(DPATH_LAT)) || (hoz == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int H_W       = 10,
    parameter int V_W       = 10,
    parameter int PW        = 8,
    parameter int DPATH_LAT = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pix_en,
    input  logic           stn_mode,
    input  logic [H_W-1:0] vh_dly,
    input  logic [H_W-1:0] h_pulse,
    input  logic [H_W-1:0] h_back,
    input  logic [H_W-1:0] h_front,
    input  logic [H_W-1:0] h_active,
    input  logic [V_W-1:0] v_pulse,
    input  logic [V_W-1:0] v_back,
    input  logic [V_W-1:0] v_front,
    input  logic [V_W-1:0] v_active,
    input  logic [PW-1:0]  pclk_div,
    output logic           hsync,
    output logic           vsync,
    output logic           de,
    output logic [H_W-1:0] pix_x,
    output logic [V_W-1:0] line_y,
    output logic           cfg_err
);

    localparam int LW = V_W + 2;

    typedef struct packed {
        logic           stn;
        logic [H_W-1:0] vh;
        logic [H_W-1:0] hpw;
        logic [H_W-1:0] hbp;
        logic [H_W-1:0] hoz;
        logic [H_W-1:0] hfp;
        logic [V_W-1:0] vpw;
        logic [V_W-1:0] vbp;
        logic [V_W-1:0] vfp;
        logic [V_W-1:0] lv;
    } cfg_t;

    typedef struct packed {
        logic run;
        cfg_t cfg;
    } top_t;

    top_t top_d, top_q;

    logic           adv;
    hphase_e        phase;
    logic [H_W-1:0] hcnt;
    logic           line_end;
    logic [LW-1:0]  vline;
    logic           frame_end;
    logic [LW-1:0]  last_line;
    logic [LW-1:0]  first_act;
    logic           act_row;
    logic [LW-1:0]  row_idx;

    assign adv = pix_en && top_q.run;

    lcd_hline #(.H_W(H_W)) u_hline (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .len_dly   (top_q.cfg.vh),
        .len_sync  (top_q.cfg.hpw),
        .len_back  (top_q.cfg.hbp),
        .len_act   (top_q.cfg.hoz),
        .len_front (top_q.cfg.hfp),
        .phase     (phase),
        .cnt       (hcnt),
        .line_end  (line_end)
    );

    lcd_vframe #(.LW(LW)) u_vframe (
        .clk       (clk),
        .rst       (rst),
        .line_end  (line_end),
        .last_line (last_line),
        .vline     (vline),
        .frame_end (frame_end)
    );

    lcd_cfg_check #(.H_W(H_W), .PW(PW), .DPATH_LAT(DPATH_LAT)) u_check (
        .clk (clk),
        .rst (rst),
        .vh  (vh_dly),
        .hpw (h_pulse),
        .hbp (h_back),
        .hoz (h_active),
        .per (pclk_div),
        .err (cfg_err)
    );

    // Frame geometry from the shadowed settings.
    always_comb begin
        first_act = LW'(top_q.cfg.vpw) + LW'(1) + LW'(top_q.cfg.vbp);
        if (top_q.cfg.stn) begin
            last_line = LW'(top_q.cfg.lv);
        end else begin
            last_line = first_act + LW'(top_q.cfg.lv) + LW'(top_q.cfg.vfp);
        end
    end

    // Shadow load on the first tick after reset and at each frame wrap.
    always_comb begin
        top_d = top_q;
        if (pix_en) begin
            top_d.run = 1'b1;
        end
        if ((pix_en && !top_q.run) || frame_end) begin
            top_d.cfg = '{stn: stn_mode, vh: vh_dly, hpw: h_pulse, hbp: h_back,
                          hoz: h_active, hfp: h_front, vpw: v_pulse, vbp: v_back,
                          vfp: v_front, lv: v_active};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    // Output decode.
    always_comb begin
        if (top_q.cfg.stn) begin
            act_row = 1'b1;
            row_idx = vline;
            vsync   = top_q.run &&
                      (((vline == LW'(0)) && (phase >= PH_ACT)) ||
                       ((vline == LW'(1)) && (phase <  PH_ACT)));
        end else begin
            act_row = (vline >= first_act) &&
                      (vline <= first_act + LW'(top_q.cfg.lv));
            row_idx = vline - first_act;
            vsync   = top_q.run && (vline <= LW'(top_q.cfg.vpw));
        end
        hsync  = top_q.run && (phase == PH_SYNC);
        de     = top_q.run && act_row && (phase == PH_ACT);
        pix_x  = de ? hcnt : '0;
        line_y = de ? row_idx[V_W-1:0] : '0;
    end

endmodule

// File: rtl/lcd_sync_chk.sv
module lcd_sync_chk #(
    parameter int H_W = 10,
    parameter int V_W = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           pix_en,
    input logic           hsync,
    input logic           vsync,
    input logic           de,
    input logic [H_W-1:0] pix_x,
    input logic [V_W-1:0] line_y
);

    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R7: one edge after reset is seen, all strobes are low.
    always @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            assert_reset_quiet_R7: assert (!hsync && !vsync && !de)
                else $error("R7 outputs active after reset");
        end
    end

    // R1: no pixel tick, no change.
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable({hsync, vsync, de, pix_x, line_y}));

    // R2: sync and data phases never overlap.
    assert_sync_vs_data_R2: assert property (@(posedge clk) disable iff (rst)
        !(hsync && de));

    // R3: indices are parked at zero outside active pixels.
    assert_idx_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !de |-> (pix_x == '0) && (line_y == '0));

    // R3: a run of active pixels starts at column 0.
    assert_first_col_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(de) |-> (pix_x == '0));

endmodule

bind lcd_sync_gen lcd_sync_chk #(.H_W(H_W), .V_W(V_W)) u_sync_chk (
    .clk    (clk),
    .rst    (rst),
    .pix_en (pix_en),
    .hsync  (hsync),
    .vsync  (vsync),
    .de     (de),
    .pix_x  (pix_x),
    .line_y (line_y)
);

// File: tb/lcd_sync_gen_test.sv
`timescale 1ns/1ps
module lcd_sync_gen_test;

    localparam int HW  = 10;
    localparam int VW  = 10;
    localparam int PWD = 8;
    localparam int LAT = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pix_en = 1'b0;
    logic          stn_mode = 1'b0;
    logic [HW-1:0] vh_dly = '0, h_pulse = '0, h_back = '0, h_front = '0, h_active = '0;
    logic [VW-1:0] v_pulse = '0, v_back = '0, v_front = '0, v_active = '0;
    logic [PWD-1:0] pclk_div = 8'd2;
    logic          hsync, vsync, de, cfg_err;
    logic [HW-1:0] pix_x;
    logic [VW-1:0] line_y;

    lcd_sync_gen #(.H_W(HW), .V_W(VW), .PW(PWD), .DPATH_LAT(LAT)) uut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .stn_mode(stn_mode),
        .vh_dly(vh_dly), .h_pulse(h_pulse), .h_back(h_back), .h_front(h_front),
        .h_active(h_active), .v_pulse(v_pulse), .v_back(v_back), .v_front(v_front),
        .v_active(v_active), .pclk_div(pclk_div), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_x(pix_x), .line_y(line_y), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string scen = "R7";

    // Reference model state: ticks since frame start plus the shadowed settings.
    int started = 0, t = 0;
    int s_stn, s_vh, s_hpw, s_hbp, s_hoz, s_hfp, s_vpw, s_vbp, s_vfp, s_lv;
    int e_hs, e_vs, e_de, e_px, e_py, e_err;
    int tick_prev = 1, rst_prev = 1, have_prev = 0, check_on = 0;
    logic [HW-1:0] p_px;
    logic [VW-1:0] p_py;
    logic p_hs, p_vs, p_de;

    function automatic int line_len();
        return s_vh + s_hpw + s_hbp + s_hoz + s_hfp + 5;
    endfunction

    function automatic int frame_lines();
        if (s_stn != 0) return s_lv + 1;
        return s_vpw + 1 + s_vbp + s_lv + 1 + s_vfp;
    endfunction

    task automatic load_shadow();
        s_stn = int'(stn_mode); s_vh = int'(vh_dly); s_hpw = int'(h_pulse);
        s_hbp = int'(h_back); s_hoz = int'(h_active); s_hfp = int'(h_front);
        s_vpw = int'(v_pulse); s_vbp = int'(v_back); s_vfp = int'(v_front);
        s_lv = int'(v_active);
    endtask

    task automatic model_outputs();
        int len, ln, p, a, b, c, d, first, actl, row;
        e_hs = 0; e_vs = 0; e_de = 0; e_px = 0; e_py = 0;
        if (started == 0) return;
        len = line_len();
        ln = t / len;
        p = t % len;
        a = s_vh + 1;
        b = a + s_hpw + 1;
        c = b + s_hbp + 1;
        d = c + s_hoz + 1;
        e_hs = (p >= a && p < b) ? 1 : 0;
        if (s_stn != 0) begin
            e_vs = ((ln == 0 && p >= c) || (ln == 1 && p < c)) ? 1 : 0;
            actl = 1;
            row = ln;
        end else begin
            first = s_vpw + 1 + s_vbp;
            e_vs = (ln <= s_vpw) ? 1 : 0;
            actl = (ln >= first && ln <= first + s_lv) ? 1 : 0;
            row = ln - first;
        end
        if (actl != 0 && p >= c && p < d) begin
            e_de = 1; e_px = p - c; e_py = row;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        tick_prev = int'(pix_en);
        rst_prev = int'(rst);
        if (rst) begin
            e_err = 0;
        end else begin
            e_err = (((int'(vh_dly) + int'(h_pulse) + int'(h_back) + 3) * int'(pclk_div) < LAT)
                     || h_active == '0) ? 1 : 0;
        end
        if (rst) begin
            started = 0; t = 0;
        end else if (pix_en) begin
            if (started == 0) begin
                started = 1; t = 0; load_shadow();
            end else begin
                t++;
                if (t >= line_len() * frame_lines()) begin
                    t = 0; load_shadow();
                end
            end
        end
        model_outputs();
        check_on = 1;
    end

    task automatic chk(string req, string sig, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] %s at cycle %0d: actual %0d expected %0d",
                     req, scen, sig, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (check_on != 0) begin
            chk("R2", "hsync", int'(hsync), e_hs);
            chk((s_stn != 0) ? "R5" : "R4", "vsync", int'(vsync), e_vs);
            chk("R3", "de", int'(de), e_de);
            chk("R3", "pix_x", int'(pix_x), e_px);
            chk("R4", "line_y", int'(line_y), e_py);
            chk("R8", "cfg_err", int'(cfg_err), e_err);
            if (have_prev != 0 && tick_prev == 0 && rst_prev == 0) begin
                // R1: outputs frozen across an edge without a pixel tick
                chk("R1", "hold", int'({hsync, vsync, de, pix_x, line_y} ==
                                         {p_hs, p_vs, p_de, p_px, p_py}), 1);
            end
            p_hs = hsync; p_vs = vsync; p_de = de; p_px = pix_x; p_py = line_y;
            have_prev = 1;
        end
    end

    task automatic set_cfg(input int stn, input int vh, input int hpw, input int hbp,
                           input int hoz, input int hfp, input int vpw, input int vbp,
                           input int vfp, input int lv);
        @(negedge clk);
        stn_mode = stn[0];
        vh_dly = HW'(vh); h_pulse = HW'(hpw); h_back = HW'(hbp);
        h_active = HW'(hoz); h_front = HW'(hfp);
        v_pulse = VW'(vpw); v_back = VW'(vbp); v_front = VW'(vfp); v_active = VW'(lv);
    endtask

    task automatic run(input int n, input int sparse);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_en = (sparse != 0) ? (($urandom % 3) == 0) : 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pix_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // R7: reset state and idle before the first tick
        scen = "R7";
        set_cfg(0, 1, 1, 2, 3, 1, 1, 1, 1, 2);
        do_reset();
        run(1, 0);
        pix_en = 1'b0;
        repeat (6) @(negedge clk);

        // R2 R3 R4: TFT frames at full rate (13-tick lines, 7 lines)
        scen = "R2 R3 R4";
        run(200, 0);

        // R1: irregular pixel enables
        scen = "R1";
        run(400, 1);

        // R6: rewrite timing mid-frame; takes hold only at the next frame
        scen = "R6";
        run(30, 0);
        set_cfg(0, 0, 2, 0, 4, 2, 0, 2, 0, 1);
        run(300, 0);

        // R5: STN, vertical settings nonzero but ignored
        scen = "R5";
        set_cfg(1, 0, 0, 1, 2, 0, 3, 2, 2, 3);
        do_reset();
        run(120, 0);
        run(200, 1);

        // R2 R4: all porches at minimum, two-pixel lines, one active line
        scen = "R2 R4 min";
        set_cfg(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        do_reset();
        run(80, 0);

        // R8: legality bound swept around the latency limit
        scen = "R8";
        set_cfg(0, 1, 1, 2, 3, 1, 1, 1, 1, 2);
        @(negedge clk); pclk_div = 8'd2;
        run(5, 0);
        @(negedge clk); pclk_div = 8'd1;
        run(5, 0);
        set_cfg(0, 2, 2, 2, 3, 1, 1, 1, 1, 2);
        run(5, 0);
        set_cfg(0, 1, 1, 2, 0, 1, 1, 1, 1, 2);
        @(negedge clk); pclk_div = 8'd4;
        run(5, 0);
        set_cfg(0, 1, 1, 2, 3, 1, 1, 1, 1, 2);
        run(5, 0);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule